// File: doc/BRIEF.md
# Multi-Channel Prescaled Down-Count Timer

This peripheral holds several independent down-counting timer channels behind a small 32-bit register interface. Each channel has a control word, a load value and a readable count. Software writes a load value and then sets the channel's enable bit. The channel divides the input clock by its own 8-bit prescale value plus one, and it decrements its 24-bit count once per divided tick.

When a channel expires, it raises its flag in a shared status word. In periodic mode the channel reloads from the load register and keeps running. In one-shot mode it parks at zero and clears its own enable bit. Each channel drives a level interrupt line, which is gated by that channel's interrupt enable. Software clears flags by writing ones to the status word.

Register layout:
- Each channel `i` sits at byte offset `0x10*i`:
  - `+0x0` is control.
  - `+0x4` is load.
  - `+0x8` is count, which is read-only.
- The status word sits at `0x80`.
- Addresses with bits 1:0 non-zero, registers at `+0xC`, and channel slots at or above the channel count are unmapped.

Top module: `tmr_multi`

## Requirements
- R1: After reset every control, load and count register reads zero, the status word reads zero and every interrupt output is low.
- R2: Control bits [7:0] hold a prescale value P. An enabled channel ticks once every P+1 clock cycles. In one-shot mode with load L (L of 0 acts as 1), the flag appears (P+1)*L clock edges after the edge that writes control with bit 30 set.
- R3: Reading the count register (offset +0x8) returns the live count in bits [23:0]. The count starts at the load value when the channel is enabled and falls by one on each tick.
- R4: With mode bits [28:27] = 01 (periodic), an expiring channel reloads from its load register, sets its flag again every (P+1)*L cycles, and keeps control bit 30 set.
- R5: With mode bits [28:27] other than 01, one-shot applies. After expiry the count reads 0, control bit 30 reads 0, and no further flag is raised. Setting bit 30 again re-arms the channel from the load register.
- R6: At address 0x80, status bit i is channel i's flag. A write clears exactly the bits written as one: 0x1f clears all five, and 0 changes nothing. A flag set in the same cycle as a clear stays set.
- R7: Interrupt output i is high exactly while status bit i is set and control bit 29 (interrupt enable) of channel i is set.
- R8: Writing zero to a channel's control register stops it. The count holds its value, no flag is raised and its interrupt output stays low.
- R9: Writing the load register of an enabled channel makes the count take the new value on the next tick. Expiry follows L ticks later.
- R10: Control bits 31 and 26:8 are ignored and read zero, and load bits 31:24 are ignored and read zero. Writes to the count register or to unmapped addresses change nothing, and unmapped addresses read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | Write when high, read when low |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from address |
| irq | output | 5 | Per-channel interrupt lines |

## Verification
Several rules are checked by properties on every cycle:
- the prescaler's tick spacing;
- the single-step decrement;
- the periodic reload and the one-shot stop at expiry;
- a pending load being taken on the next tick;
- a count freezing while disabled;
- a flag following every expiry;
- the interrupt gating.

The absolute expiry latency (P+1)*L as seen at the pins needs scenarios, which sweep prescale and load values over all five channels. The same applies to the write-one-to-clear selectivity, the re-arm of a one-shot channel, the reserved-bit masking and the unmapped-address behaviour.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int PSC_W = 8;
    localparam int BIT_EN = 30;
    localparam int BIT_IE = 29;
    localparam int MODE_HI = 28;
    localparam int MODE_LO = 27;

    typedef enum logic [1:0] {
        MODE_ONESHOT  = 2'b00,
        MODE_PERIODIC = 2'b01
    } mode_e;

    typedef struct packed {
        logic             en;
        logic             ie;
        logic [1:0]       mode;
        logic [PSC_W-1:0] psc;
    } ctrl_t;

    typedef enum logic [1:0] {
        SEL_CTRL  = 2'd0,
        SEL_LOAD  = 2'd1,
        SEL_COUNT = 2'd2
    } regsel_e;

    function automatic ctrl_t ctrl_make(logic en, logic ie, logic [1:0] mode,
                                        logic [PSC_W-1:0] psc);
        ctrl_t c;
        c.en   = en;
        c.ie   = ie;
        c.mode = mode;
        c.psc  = psc;
        return c;
    endfunction

    function automatic logic [31:0] ctrl_word(ctrl_t c);
        logic [31:0] w;
        w = '0;
        w[BIT_EN] = c.en;
        w[BIT_IE] = c.ie;
        w[MODE_HI:MODE_LO] = c.mode;
        w[PSC_W-1:0] = c.psc;
        return w;
    endfunction

    function automatic logic is_periodic(ctrl_t c);
        return mode_e'(c.mode) == MODE_PERIODIC;
    endfunction

endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
    import tmr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [PSC_W-1:0] psc,
    output logic             tick
);

    logic [PSC_W-1:0] div_q;

    assign tick = en && (div_q >= psc);

    always_ff @(posedge clk) begin
        if (rst || !en || tick) begin
            div_q <= '0;
        end else begin
            div_q <= div_q + PSC_W'(1);
        end
    end

    // R2: a non-unity divider never ticks on two consecutive cycles
    p_tick_gap_r2: assert property (@(posedge clk) disable iff (rst)
        (tick && psc != '0) |=> (!tick || psc == '0));

endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
    import tmr_pkg::*;
#(
    parameter int CW = 24
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_ctrl,
    input  ctrl_t         ctrl_in,
    input  logic          wr_load,
    input  logic [CW-1:0] load_in,
    output ctrl_t         ctrl_o,
    output logic [CW-1:0] load_o,
    output logic [CW-1:0] cnt_o,
    output logic          expire_o
);

    ctrl_t         ctrl_q;
    logic [CW-1:0] load_q;
    logic [CW-1:0] cnt_q;
    logic          pend_q;
    logic          tick;
    logic          last;

    tmr_prescaler u_div (
        .clk  (clk),
        .rst  (rst),
        .en   (ctrl_q.en),
        .psc  (ctrl_q.psc),
        .tick (tick)
    );

    assign last     = cnt_q < CW'(2);
    assign expire_o = tick && !pend_q && last && !wr_ctrl;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            load_q <= '0;
            cnt_q  <= '0;
            pend_q <= 1'b0;
        end else begin
            if (wr_load) begin
                load_q <= load_in;
            end
            if (wr_ctrl) begin
                ctrl_q <= ctrl_in;
                if (ctrl_in.en && !ctrl_q.en) begin
                    cnt_q  <= load_q;
                    pend_q <= 1'b0;
                end else if (!ctrl_in.en) begin
                    pend_q <= 1'b0;
                end
            end else if (tick) begin
                if (pend_q) begin
                    cnt_q  <= load_q;
                    pend_q <= 1'b0;
                end else if (last) begin
                    if (is_periodic(ctrl_q)) begin
                        cnt_q <= load_q;
                    end else begin
                        cnt_q     <= '0;
                        ctrl_q.en <= 1'b0;
                    end
                end else begin
                    cnt_q <= cnt_q - CW'(1);
                end
            end
            if (wr_load && ctrl_q.en) begin
                pend_q <= 1'b1;
            end
        end
    end

    assign ctrl_o = ctrl_q;
    assign load_o = load_q;
    assign cnt_o  = cnt_q;

    // R3: an ordinary tick lowers the count by exactly one
    p_step_r3: assert property (@(posedge clk) disable iff (rst)
        (tick && !pend_q && !last && !wr_ctrl) |=> cnt_o == $past(cnt_o) - CW'(1));

    // R4: a periodic expiry reloads and stays enabled
    p_reload_r4: assert property (@(posedge clk) disable iff (rst)
        (expire_o && is_periodic(ctrl_o)) |=> (ctrl_o.en && cnt_o == $past(load_o)));

    // R5: a one-shot expiry parks the channel
    p_park_r5: assert property (@(posedge clk) disable iff (rst)
        (expire_o && !is_periodic(ctrl_o)) |=> (!ctrl_o.en && cnt_o == '0));

    // R8: a disabled channel holds its count
    p_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (!ctrl_o.en && !wr_ctrl) |=> $stable(cnt_o));

    // R9: a pending load is taken on the next tick
    p_pend_r9: assert property (@(posedge clk) disable iff (rst)
        (tick && pend_q && !wr_ctrl) |=> cnt_o == $past(load_o));

endmodule

// File: rtl/tmr_multi.sv
module tmr_multi
    import tmr_pkg::*;
#(
    parameter int NCH = 5,
    parameter int CW  = 24
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           bus_sel,
    input  logic           bus_wr,
    input  logic [7:0]     bus_addr,
    input  logic [31:0]    bus_wdata,
    output logic [31:0]    bus_rdata,
    output logic [NCH-1:0] irq
);

    localparam logic [7:0] STAT_ADDR = 8'h80;

    ctrl_t          ch_ctrl [NCH];
    logic [CW-1:0]  ch_load [NCH];
    logic [CW-1:0]  ch_cnt  [NCH];
    logic [NCH-1:0] ch_exp;
    logic [NCH-1:0] wr_ctrl_v;
    logic [NCH-1:0] wr_load_v;
    logic [NCH-1:0] flags_q;
    logic [NCH-1:0] clr_v;

    logic [2:0] ch_idx;
    regsel_e    reg_sel;
    logic       ch_space;
    logic       hit_stat;
    ctrl_t      ctrl_new;
    logic       unused_bits;

    assign ch_idx   = bus_addr[6:4];
    assign reg_sel  = regsel_e'(bus_addr[3:2]);
    assign ch_space = !bus_addr[7] && (bus_addr[1:0] == 2'b00);
    assign hit_stat = bus_addr == STAT_ADDR;
    assign ctrl_new = ctrl_make(bus_wdata[BIT_EN], bus_wdata[BIT_IE],
                                bus_wdata[MODE_HI:MODE_LO], bus_wdata[PSC_W-1:0]);
    assign unused_bits = ^{bus_wdata[31], bus_wdata[26:24]};

    assign clr_v = (bus_sel && bus_wr && hit_stat) ? bus_wdata[NCH-1:0] : '0;

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        assign wr_ctrl_v[i] = bus_sel && bus_wr && ch_space &&
                              ch_idx == 3'(i) && reg_sel == SEL_CTRL;
        assign wr_load_v[i] = bus_sel && bus_wr && ch_space &&
                              ch_idx == 3'(i) && reg_sel == SEL_LOAD;

        tmr_channel #(.CW(CW)) u_ch (
            .clk      (clk),
            .rst      (rst),
            .wr_ctrl  (wr_ctrl_v[i]),
            .ctrl_in  (ctrl_new),
            .wr_load  (wr_load_v[i]),
            .load_in  (bus_wdata[CW-1:0]),
            .ctrl_o   (ch_ctrl[i]),
            .load_o   (ch_load[i]),
            .cnt_o    (ch_cnt[i]),
            .expire_o (ch_exp[i])
        );

        assign irq[i] = flags_q[i] && ch_ctrl[i].ie;

        // R6: every expiry leaves its flag set, even against a clear
        p_flag_set_r6: assert property (@(posedge clk) disable iff (rst)
            ch_exp[i] |=> flags_q[i]);

        // R7: no interrupt without the channel's enable bit
        p_irq_gate_r7: assert property (@(posedge clk) disable iff (rst)
            !ch_ctrl[i].ie |-> !irq[i]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q <= '0;
        end else begin
            flags_q <= (flags_q & ~clr_v) | ch_exp;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (hit_stat) begin
            bus_rdata = 32'(flags_q);
        end else if (ch_space) begin
            for (int k = 0; k < NCH; k++) begin
                if (ch_idx == 3'(k)) begin
                    case (reg_sel)
                        SEL_CTRL:  bus_rdata = ctrl_word(ch_ctrl[k]);
                        SEL_LOAD:  bus_rdata = 32'(ch_load[k]);
                        SEL_COUNT: bus_rdata = 32'(ch_cnt[k]);
                        default:   bus_rdata = '0;
                    endcase
                end
            end
        end
    end

endmodule

// File: tb/test_tmr_multi.sv
module test_tmr_multi;

    localparam int NCH = 5;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           bus_sel = 1'b0;
    logic           bus_wr = 1'b0;
    logic [7:0]     bus_addr = '0;
    logic [31:0]    bus_wdata = '0;
    logic [31:0]    bus_rdata;
    logic [NCH-1:0] irq;

    int vectors = 0;
    int errors = 0;

    tmr_multi i_tmr_multi (
        .clk       (clk),
        .rst       (rst),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    always #4 clk = ~clk;

    task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
        vectors++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // called at a negedge; returns at the negedge after the write edge
    task automatic wr(logic [7:0] a, logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(logic [7:0] a, output logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1;
        d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic wait_irq(int ch, int limit, output int n);
        n = 0;
        while (!irq[ch] && n < limit) begin
            @(negedge clk);
            n++;
        end
    endtask

    function automatic logic [7:0] ctl_a(int ch);
        return 8'(ch * 16);
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog R2: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        logic [31:0] d;
        logic [31:0] c0;
        int n;

        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        for (int ch = 0; ch < NCH; ch++) begin
            for (int r = 0; r < 3; r++) begin
                rd(ctl_a(ch) + 8'(4 * r), d);
                chk("R1 register after reset", d, 32'h0);
            end
        end
        rd(8'h80, d);
        chk("R1 status after reset", d, 32'h0);
        chk("R1 irq after reset", 32'(irq), 32'h0);

        // R10: reserved bits, load width, count and unmapped writes
        wr(8'h00, 32'h87FF_FF00);
        rd(8'h00, d);
        chk("R10 reserved control bits", d, 32'h0);
        wr(8'h00, 32'h1800_0000);
        rd(8'h00, d);
        chk("R10 mode field readback", d, 32'h1800_0000);
        wr(8'h00, 32'h0);
        wr(8'h04, 32'hABCD_EF12);
        rd(8'h04, d);
        chk("R10 load upper byte", d, 32'h00CD_EF12);
        wr(8'h08, 32'h0000_1234);
        rd(8'h08, d);
        chk("R10 count write ignored", d, 32'h0);
        wr(8'h60, 32'hFFFF_FFFF);
        rd(8'h60, d);
        chk("R10 unmapped read", d, 32'h0);
        wr(8'h0C, 32'hFFFF_FFFF);
        rd(8'h0C, d);
        chk("R10 unmapped slot", d, 32'h0);
        rd(8'h00, d);
        chk("R10 control untouched", d, 32'h0);

        // R2 R5: one-shot sweep, re-armed on every channel
        for (int ch = 0; ch < NCH; ch++) begin
            for (int p = 0; p < 3; p++) begin
                for (int l = 0; l < 3; l++) begin
                    int pv;
                    int lv;
                    pv = (p == 2) ? 3 : p;
                    lv = (l == 2) ? 5 : l + 1;
                    wr(ctl_a(ch) + 8'h4, 32'(lv));
                    wr(ctl_a(ch), 32'h6000_0000 | 32'(pv));
                    wait_irq(ch, 200, n);
                    chk("R2 one-shot latency", 32'(n), 32'((pv + 1) * lv));
                    rd(8'h80, d);
                    chk("R6 flag position", d, 32'(1) << ch);
                    rd(ctl_a(ch), d);
                    chk("R5 enable cleared", d, 32'h2000_0000 | 32'(pv));
                    rd(ctl_a(ch) + 8'h8, d);
                    chk("R5 count parked", d, 32'h0);
                    wr(8'h80, 32'(1) << ch);
                    chk("R7 irq after clear", 32'(irq), 32'h0);
                    repeat (2 * (pv + 1) * lv + 4) @(negedge clk);
                    rd(8'h80, d);
                    chk("R5 no refire", d, 32'h0);
                end
            end
        end

        // R2: load of zero acts as one
        wr(8'h04, 32'h0);
        wr(8'h00, 32'h6000_0002);
        wait_irq(0, 100, n);
        chk("R2 zero load", 32'(n), 32'd3);
        wr(8'h80, 32'h1f);

        // R3: live count
        wr(8'h24, 32'd10);
        wr(8'h20, 32'h6000_0001);
        rd(8'h28, d);
        chk("R3 count at enable", d, 32'd10);
        repeat (4) @(negedge clk);
        rd(8'h28, d);
        chk("R3 count after two ticks", d, 32'd8);
        wr(8'h20, 32'h0);

        // R4: periodic
        wr(8'h34, 32'd4);
        wr(8'h30, 32'h6800_0002);
        wait_irq(3, 200, n);
        chk("R4 first period", 32'(n), 32'd12);
        wr(8'h80, 32'h08);
        wait_irq(3, 200, n);
        chk("R4 second period", 32'(n), 32'd11);
        rd(8'h30, d);
        chk("R4 still enabled", d, 32'h6800_0002);
        wr(8'h80, 32'h08);

        // R8: stop by writing zero
        wr(8'h30, 32'h0);
        rd(8'h38, c0);
        repeat (40) @(negedge clk);
        rd(8'h38, d);
        chk("R8 count holds", d, c0);
        rd(8'h80, d);
        chk("R8 no flag", d, 32'h0);
        chk("R8 irq low", 32'(irq[3]), 32'h0);

        // R9: load rewrite while running
        wr(8'h44, 32'd20);
        wr(8'h40, 32'h6800_0000);
        repeat (3) @(negedge clk);
        wr(8'h44, 32'd5);
        wait_irq(4, 100, n);
        chk("R9 latency after reload", 32'(n), 32'd6);
        rd(8'h48, d);
        chk("R9 reloaded count", d, 32'd5);
        wr(8'h40, 32'h0);
        wr(8'h80, 32'h1f);

        // R7: interrupt gating
        wr(8'h14, 32'd3);
        wr(8'h10, 32'h4000_0000);
        repeat (6) @(negedge clk);
        chk("R7 irq masked", 32'(irq[1]), 32'h0);
        rd(8'h80, d);
        chk("R7 flag without enable", d, 32'h02);
        wr(8'h10, 32'h2000_0000);
        chk("R7 irq on enable", 32'(irq[1]), 32'h1);
        wr(8'h80, 32'h1f);

        // R6: selective clear
        wr(8'h04, 32'd2);
        wr(8'h14, 32'd2);
        wr(8'h00, 32'h6000_0000);
        wr(8'h10, 32'h6000_0000);
        repeat (6) @(negedge clk);
        rd(8'h80, d);
        chk("R6 two flags", d, 32'h03);
        wr(8'h80, 32'h0);
        rd(8'h80, d);
        chk("R6 zero write", d, 32'h03);
        wr(8'h80, 32'h1);
        rd(8'h80, d);
        chk("R6 clear one", d, 32'h02);
        wr(8'h80, 32'h1f);
        rd(8'h80, d);
        chk("R6 clear all", d, 32'h0);
        chk("R6 irq low", 32'(irq), 32'h0);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule